// File: doc/BRIEF.md
# CSR Privilege Guard

This block sits between the instruction decoder and a small control-register file in a core with three privilege levels: user, supervisor and machine. For each decoded operation it decides whether the operation may go ahead. The operation is either a CSR access (a 12-bit address with an optional write) or one of the two trap-return instructions. An accepted operation is carried out and acknowledged. A rejected one leaves all state as it was and raises an illegal-instruction exception that carries its cause code.

The register file behind the guard holds the machine interrupt-enable and interrupt-pending words and one scratch word per privilege level. The supervisor interrupt-enable and interrupt-pending words have no storage of their own. They are windows onto the machine words, restricted to the supervisor interrupt positions. Every result is registered, so the response to an operation offered in one cycle appears in the next cycle.

Top module: `csr_priv_guard`

## Requirements
- R1: The privilege levels are encoded user=00, supervisor=01, machine=11. A CSR access is allowed only when cur_lvl is numerically greater than or equal to csr_addr[9:8]. A lower level is rejected, so a write from supervisor to a machine-level address such as 0x300, 0x302 or 0x305 traps.
- R2: A CSR write (csr_wr=1) to an address whose bits [11:10] are 11 traps at every level. A read of such an address obeys only R1.
- R3: A rejected operation sets trap_valid in the cycle after op_valid, for that one cycle only, with trap_cause equal to 2. In that cycle done_ok is 0 and rsp_data is 0.
- R4: An operation with ret_m=1 is accepted only at machine level. At any other level it traps.
- R5: An operation with ret_s=1 (and ret_m=0) is accepted at machine or supervisor level. At user level it traps.
- R6: mscratch (0x340) and sscratch (0x140) hold full words. A supervisor can access sscratch. rsp_data returns the value held before the operation, and a later read returns the value written.
- R7: sie (0x104) reads as mie (0x304) ANDed with the supervisor mask, and sip (0x144) reads as mip (0x344) ANDed with the same mask. The mask has bits 1, 5 and 9 set, and every other bit reads as 0.
- R8: A write to sie or sip changes only the mask bits of mie or mip. All other bits of those words keep their values.
- R9: A rejected operation changes no stored register.
- R10: An accepted operation sets done_ok in the cycle after op_valid. Addresses outside the six listed above read as 0, and writes to them have no effect.
- R11: After reset, trap_valid, done_ok and rsp_data are 0 and all four stored words are 0.
- R12: When ret_m or ret_s is set, the CSR fields are ignored. No register is written, and an accepted return gives rsp_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered this cycle |
| cur_lvl | input | 2 | Current privilege level |
| csr_addr | input | 12 | CSR address |
| csr_wr | input | 1 | The CSR operation writes |
| csr_wdata | input | XLEN | Write data |
| ret_m | input | 1 | Machine trap return |
| ret_s | input | 1 | Supervisor trap return |
| done_ok | output | 1 | Operation accepted (one cycle later) |
| trap_valid | output | 1 | Illegal-instruction exception (one cycle later) |
| trap_cause | output | 4 | Exception cause code |
| rsp_data | output | XLEN | Old CSR value for an accepted access |

## Verification
The bench builds the guard with XLEN=32. It sweeps all three legal privilege levels against fifteen addresses, both reading and writing, in two passes with different data. The addresses cover all four values of bits [9:8] and both the writable and read-only values of bits [11:10]. Because sie, sip and the machine words are interleaved in every pass, masked merges are exercised against arbitrary prior contents. Every return instruction is offered at every level with a conflicting CSR write attached, and a final machine-level readback confirms that rejected operations and returns left storage untouched.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;

    typedef enum logic [1:0] {
        LVL_USER    = 2'b00,
        LVL_SUPER   = 2'b01,
        LVL_RSVD    = 2'b10,
        LVL_MACHINE = 2'b11
    } lvl_e;

    localparam logic [3:0] CAUSE_BAD_INSN = 4'd2;

    localparam logic [11:0] A_SIE  = 12'h104;
    localparam logic [11:0] A_SSCR = 12'h140;
    localparam logic [11:0] A_SIP  = 12'h144;
    localparam logic [11:0] A_MIE  = 12'h304;
    localparam logic [11:0] A_MSCR = 12'h340;
    localparam logic [11:0] A_MIP  = 12'h344;

    localparam int SSI_POS = 1;
    localparam int STI_POS = 5;
    localparam int SEI_POS = 9;

    typedef struct packed {
        logic [11:0] addr;
        logic        wr;
        logic        mret;
        logic        sret;
    } req_t;

    function automatic logic lvl_reaches(logic [1:0] cur, logic [11:0] addr);
        return cur >= addr[9:8];
    endfunction

    function automatic logic ro_space(logic [11:0] addr);
        return addr[11:10] == 2'b11;
    endfunction

    function automatic logic sup_bit(int pos);
        return (pos == SSI_POS) || (pos == STI_POS) || (pos == SEI_POS);
    endfunction

endpackage

// File: rtl/csr_lvl_gate.sv
module csr_lvl_gate
    import csr_guard_pkg::*;
(
    input  req_t       req,
    input  logic [1:0] cur_lvl,
    output logic       allow,
    output logic       do_write
);
    lvl_e lvl;
    assign lvl = lvl_e'(cur_lvl);

    always_comb begin
        if (req.mret) begin
            allow = (lvl == LVL_MACHINE);
        end else if (req.sret) begin
            allow = (lvl == LVL_MACHINE) || (lvl == LVL_SUPER);
        end else begin
            allow = lvl_reaches(cur_lvl, req.addr) && !(req.wr && ro_space(req.addr));
        end
        do_write = allow && req.wr && !req.mret && !req.sret;
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_guard_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     addr,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] mie_q,
    output logic [XLEN-1:0] mip_q,
    output logic [XLEN-1:0] mscr_q,
    output logic [XLEN-1:0] sscr_q
);
    logic [XLEN-1:0] smask;

    for (genvar b = 0; b < XLEN; b++) begin : g_mask
        assign smask[b] = sup_bit(b);
    end

    always_comb begin
        unique case (addr)
            A_MIE:   rdata = mie_q;
            A_MIP:   rdata = mip_q;
            A_SIE:   rdata = mie_q & smask;
            A_SIP:   rdata = mip_q & smask;
            A_MSCR:  rdata = mscr_q;
            A_SSCR:  rdata = sscr_q;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mie_q  <= '0;
            mip_q  <= '0;
            mscr_q <= '0;
            sscr_q <= '0;
        end else if (we) begin
            unique case (addr)
                A_MIE:   mie_q  <= wdata;
                A_MIP:   mip_q  <= wdata;
                A_SIE:   mie_q  <= (mie_q & ~smask) | (wdata & smask);
                A_SIP:   mip_q  <= (mip_q & ~smask) | (wdata & smask);
                A_MSCR:  mscr_q <= wdata;
                A_SSCR:  sscr_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csr_priv_guard.sv
module csr_priv_guard
    import csr_guard_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [1:0]      cur_lvl,
    input  logic [11:0]     csr_addr,
    input  logic            csr_wr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            ret_m,
    input  logic            ret_s,
    output logic            done_ok,
    output logic            trap_valid,
    output logic [3:0]      trap_cause,
    output logic [XLEN-1:0] rsp_data
);
    req_t            req;
    logic            allow;
    logic            do_write;
    logic [XLEN-1:0] bank_rdata;
    logic [XLEN-1:0] mie_q, mip_q, mscr_q, sscr_q;

    assign req = '{addr: csr_addr, wr: csr_wr, mret: ret_m, sret: ret_s};

    csr_lvl_gate u_gate (
        .req      (req),
        .cur_lvl  (cur_lvl),
        .allow    (allow),
        .do_write (do_write)
    );

    csr_bank #(.XLEN(XLEN)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .addr   (csr_addr),
        .we     (op_valid && do_write),
        .wdata  (csr_wdata),
        .rdata  (bank_rdata),
        .mie_q  (mie_q),
        .mip_q  (mip_q),
        .mscr_q (mscr_q),
        .sscr_q (sscr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_ok    <= 1'b0;
            trap_valid <= 1'b0;
            trap_cause <= '0;
            rsp_data   <= '0;
        end else begin
            done_ok    <= op_valid && allow;
            trap_valid <= op_valid && !allow;
            trap_cause <= (op_valid && !allow) ? CAUSE_BAD_INSN : '0;
            rsp_data   <= (op_valid && allow && !ret_m && !ret_s) ? bank_rdata : '0;
        end
    end
endmodule

// File: rtl/csr_priv_guard_chk.sv
module csr_priv_guard_chk
    import csr_guard_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [1:0]      cur_lvl,
    input logic [11:0]     csr_addr,
    input logic            csr_wr,
    input logic            ret_m,
    input logic            ret_s,
    input logic            done_ok,
    input logic            trap_valid,
    input logic [3:0]      trap_cause,
    input logic [XLEN-1:0] mie_q,
    input logic [XLEN-1:0] mip_q,
    input logic [XLEN-1:0] mscr_q,
    input logic [XLEN-1:0] sscr_q
);
    localparam logic [XLEN-1:0] SM = (XLEN'(1) << SSI_POS) | (XLEN'(1) << STI_POS)
                                   | (XLEN'(1) << SEI_POS);

    a_r1_low_level_traps: assert property (@(posedge clk) disable iff (rst)
        op_valid && !ret_m && !ret_s && (cur_lvl < csr_addr[9:8]) |=> trap_valid);

    a_r2_ro_write_traps: assert property (@(posedge clk) disable iff (rst)
        op_valid && !ret_m && !ret_s && csr_wr && (csr_addr[11:10] == 2'b11) |=> trap_valid);

    a_r3_cause_two: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_cause == 4'd2) && $past(op_valid));

    a_r4_mret_machine_only: assert property (@(posedge clk) disable iff (rst)
        op_valid && ret_m |=> (trap_valid == ($past(cur_lvl) != 2'b11)));

    a_r5_sret_user_traps: assert property (@(posedge clk) disable iff (rst)
        op_valid && ret_s && !ret_m && (cur_lvl == 2'b00) |=> trap_valid);

    a_r8_sie_keeps_other_bits: assert property (@(posedge clk) disable iff (rst)
        op_valid && (csr_addr == A_SIE) && !ret_m && !ret_s
            |=> (mie_q & ~SM) == $past(mie_q & ~SM));

    a_r9_trap_keeps_state: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> $stable(mie_q) && $stable(mip_q) && $stable(mscr_q) && $stable(sscr_q));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(trap_valid && done_ok));

    a_r12_ret_no_write: assert property (@(posedge clk) disable iff (rst)
        op_valid && (ret_m || ret_s)
            |=> $stable(mie_q) && $stable(mip_q) && $stable(mscr_q) && $stable(sscr_q));
endmodule

bind csr_priv_guard csr_priv_guard_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .cur_lvl    (cur_lvl),
    .csr_addr   (csr_addr),
    .csr_wr     (csr_wr),
    .ret_m      (ret_m),
    .ret_s      (ret_s),
    .done_ok    (done_ok),
    .trap_valid (trap_valid),
    .trap_cause (trap_cause),
    .mie_q      (mie_q),
    .mip_q      (mip_q),
    .mscr_q     (mscr_q),
    .sscr_q     (sscr_q)
);

// File: tb/test_csr_priv_guard.sv
module test_csr_priv_guard;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam logic [31:0] SM = 32'h0000_0222;
    localparam int NADDR = 15;
    localparam logic [11:0] ADDRS [NADDR] = '{
        12'h000, 12'hC00, 12'h104, 12'h144, 12'h140, 12'h100, 12'h180, 12'h200,
        12'h300, 12'h302, 12'h305, 12'h304, 12'h344, 12'h340, 12'hF14};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [1:0] cur_lvl = 2'b00;
    logic [11:0] csr_addr = '0;
    logic csr_wr = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic ret_m = 1'b0;
    logic ret_s = 1'b0;
    logic done_ok, trap_valid;
    logic [3:0] trap_cause;
    logic [XLEN-1:0] rsp_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] m_mie = '0, m_mip = '0, m_mscr = '0, m_sscr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_priv_guard #(.XLEN(XLEN)) i_csr_priv_guard (
        .clk(clk), .rst(rst), .op_valid(op_valid), .cur_lvl(cur_lvl),
        .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .ret_m(ret_m), .ret_s(ret_s), .done_ok(done_ok), .trap_valid(trap_valid),
        .trap_cause(trap_cause), .rsp_data(rsp_data));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [11:0] a);
        case (a)
            12'h304: return m_mie;
            12'h344: return m_mip;
            12'h104: return m_mie & SM;
            12'h144: return m_mip & SM;
            12'h340: return m_mscr;
            12'h140: return m_sscr;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_write(logic [11:0] a, logic [31:0] d);
        case (a)
            12'h304: m_mie = d;
            12'h344: m_mip = d;
            12'h104: m_mie = (m_mie & ~SM) | (d & SM);
            12'h144: m_mip = (m_mip & ~SM) | (d & SM);
            12'h340: m_mscr = d;
            12'h140: m_sscr = d;
            default: ;
        endcase
    endtask

    task automatic apply(logic [1:0] lvl, logic [11:0] a, logic w, logic [31:0] d,
                         logic rm, logic rs);
        logic legal;
        logic [31:0] exp_rd;
        string ttag, dtag;
        if (rm) begin
            legal = (lvl == 2'b11); ttag = "R4";
        end else if (rs) begin
            legal = (lvl == 2'b11) || (lvl == 2'b01); ttag = "R5";
        end else if (w && a[11:10] == 2'b11) begin
            legal = 1'b0; ttag = "R2";
        end else begin
            legal = (lvl >= a[9:8]); ttag = "R1";
        end
        exp_rd = (legal && !rm && !rs) ? m_read(a) : 32'h0;
        if (rm || rs) dtag = "R12";
        else if (a == 12'h104 || a == 12'h144) dtag = "R7";
        else if (a == 12'h140 || a == 12'h340) dtag = "R6";
        else dtag = "R10";
        @(negedge clk);
        chk("R3 idle between ops", {31'b0, trap_valid}, 32'h0);
        cur_lvl = lvl; csr_addr = a; csr_wr = w; csr_wdata = d;
        ret_m = rm; ret_s = rs; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk(ttag, {31'b0, trap_valid}, {31'b0, !legal});
        chk("R10 done_ok", {31'b0, done_ok}, {31'b0, legal});
        chk("R3 cause", {28'b0, trap_cause}, legal ? 32'h0 : 32'h2);
        chk(dtag, rsp_data, exp_rd);
        if (legal && w && !rm && !rs) m_write(a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11 trap", {31'b0, trap_valid}, 32'h0);
        chk("R11 done", {31'b0, done_ok}, 32'h0);
        chk("R11 data", rsp_data, 32'h0);
        for (int i = 0; i < 4; i++) begin
            logic [11:0] ra;
            ra = (i == 0) ? 12'h304 : (i == 1) ? 12'h344 : (i == 2) ? 12'h340 : 12'h140;
            apply(2'b11, ra, 1'b0, 32'h0, 1'b0, 1'b0);
            chk("R11 storage", rsp_data, 32'h0);
        end
        for (int pass = 0; pass < 2; pass++) begin
            for (int l = 0; l < 3; l++) begin
                logic [1:0] lvl;
                lvl = (l == 0) ? 2'b00 : (l == 1) ? 2'b01 : 2'b11;
                for (int k = 0; k < NADDR; k++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [31:0] d;
                        d = 32'h9E37_79B1 * (pass * 97 + l * 31 + k * 2 + w + 1) ^ (pass ? 32'hFFFF_0000 : 32'h0);
                        apply(lvl, ADDRS[k], w[0], d, 1'b0, 1'b0);
                        apply(2'b11, ADDRS[k], 1'b0, 32'h0, 1'b0, 1'b0);
                    end
                end
            end
        end
        apply(2'b11, 12'h104, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        apply(2'b11, 12'h304, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R8 sie all ones", rsp_data, m_mie);
        apply(2'b11, 12'h144, 1'b1, 32'h0, 1'b0, 1'b0);
        apply(2'b11, 12'h344, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R8 sip clear", rsp_data & SM, 32'h0);
        for (int l = 0; l < 3; l++) begin
            logic [1:0] lvl;
            lvl = (l == 0) ? 2'b00 : (l == 1) ? 2'b01 : 2'b11;
            apply(lvl, 12'h340, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0);
            apply(lvl, 12'h140, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b1);
            apply(lvl, 12'h140, 1'b1, 32'h1234_5678, 1'b1, 1'b1);
        end
        apply(2'b11, 12'h340, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R12 mscratch kept", rsp_data, m_mscr);
        apply(2'b11, 12'h140, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R12 sscratch kept", rsp_data, m_sscr);
        apply(2'b00, 12'h304, 1'b1, 32'h5555_5555, 1'b0, 1'b0);
        apply(2'b11, 12'h304, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R9 mie after denied write", rsp_data, m_mie);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule